// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Acknowledge Gating

This block keeps the return addresses of a small 8-bit controller core. Subroutine calls and interrupt acknowledges push the current program counter. Either kind of return instruction pops the most recent address and hands it back to the core. Software cannot read or write the stack pointer or the entries. The core's sequencer drives the push and pop strobes, and the popped address appears on `ret_addr` one cycle after the pop.

The block also holds a small interrupt acknowledge gate. An incoming interrupt request is latched as pending. The gate then offers a registered "acknowledge allowed" signal, `ack_ok`, to the interrupt controller. That signal is held low while every level is in use, so a pending interrupt waits until a return frees a level. A subroutine call on a full stack is not held back. It overwrites the oldest entry, and the stack keeps only the latest eight addresses.

A three-state occupancy machine tracks the fill level. Its states are EMPTY, PARTIAL and FULL. The transitions are:
- first push (EMPTY to PARTIAL)
- last pop (PARTIAL to EMPTY)
- filling push (PARTIAL to FULL)
- releasing pop (FULL to PARTIAL)
- overflow call (FULL to FULL)
- underflow pop (EMPTY to EMPTY)

Any other combination keeps the current state.

Top module: `retaddr_stack`

## Requirements
- R1: The stack holds DEPTH (default 8) entries of PCW (default 13) bits. A push stores `pc_in`. A pop loads `ret_addr` with the most recently stored entry not yet popped (last in, first out), in the cycle after the pop. `ret_addr` holds its value between pops.
- R2: After reset, `empty`=1, `full`=0, `underflow`=0, `ack_ok`=0 and `ret_addr`=0.
- R3: `full` is 1 exactly when all DEPTH levels are occupied. `empty` is 1 exactly when none is occupied. Both flags reflect the state after the previous clock edge.
- R4: A cycle with `irq_req`=1 sets a pending flag. The next value of `ack_ok` is computed from the state as it stands after the current cycle's operations: it is 1 when the flag is pending, `irq_en`=1 in the current cycle, and the stack is not full.
- R5: While the stack is full, the pending flag is kept and `ack_ok` stays 0. After a pop frees a level, `ack_ok` returns to 1 in the cycle after that pop.
- R6: A `push_irq` on a full stack with no pop in the same cycle is ignored. The entries, the occupancy and the pending flag are all left unchanged.
- R7: A `push_call` on a full stack overwrites the oldest entry and the occupancy stays at DEPTH. The next DEPTH pops return the DEPTH newest addresses, newest first.
- R8: A pop on an empty stack leaves the pointer and the occupancy unchanged. It loads `ret_addr` with the entry at the slot just below the write pointer and drives `underflow` to 1 for one cycle.
- R9: When a pop and a push arrive in the same cycle, the pop is applied first and then the push. On a non-empty stack, `ret_addr` gets the old top, the new address takes its slot, and the occupancy is unchanged. On an empty stack, `underflow` pulses and the occupancy becomes 1.
- R10: An accepted `push_irq` clears the pending flag, unless `irq_req` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_call | input | 1 | Subroutine call: push `pc_in` |
| push_irq | input | 1 | Interrupt acknowledge: push `pc_in` unless the stack is full |
| pop_req | input | 1 | Return or return-from-interrupt: pop |
| pc_in | input | PCW | Program counter to store |
| irq_req | input | 1 | Interrupt request pulse; sets the pending flag |
| irq_en | input | 1 | 1 = interrupt unmasked |
| ret_addr | output | PCW | Last popped return address |
| full | output | 1 | All levels occupied |
| empty | output | 1 | No level occupied |
| underflow | output | 1 | One-cycle flag after a pop on an empty stack |
| ack_ok | output | 1 | Registered: interrupt may be acknowledged now |

## Verification
The bench builds the block with its default values, DEPTH=8 and PCW=13. With only eight levels, a run of ten calls wraps the 3-bit circular pointer past its origin. A short burst of pushes therefore reaches the overflow, underflow and full-stack interrupt hold-off cases many times during the random phase. The 13-bit address width keeps the random return addresses distinct enough that a wrong slot shows up at once in the popped value.

// File: rtl/retstk_pkg.sv
package retstk_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/retstk_ctrl.sv
module retstk_ctrl
    import retstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = PTRW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            irq_push_i,
    input  logic            pop_i,
    output logic            wr_en_o,
    output logic [PTRW-1:0] wr_idx_o,
    output logic            rd_en_o,
    output logic [PTRW-1:0] rd_idx_o,
    output logic            irq_taken_o,
    output logic            full_nx_o,
    output logic            full_o,
    output logic            empty_o,
    output logic            underflow_o
);
    localparam logic [CNTW-1:0] CNT_MAX = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] CNT_ONE = CNTW'(1);

    occ_state_t      state_q, state_n;
    logic [CNTW-1:0] cnt_q, cnt_a, cnt_n;
    logic [PTRW-1:0] wp_q, wp_a, wp_n;
    logic            pop_ok, full_a, push, undf_q;

    // pop is applied first, then the push
    always_comb begin
        pop_ok      = pop_i && (cnt_q != '0);
        cnt_a       = cnt_q - CNTW'(pop_ok);
        wp_a        = wp_q - PTRW'(pop_ok);
        full_a      = (cnt_a == CNT_MAX);
        irq_taken_o = irq_push_i && !full_a;
        push        = call_i || irq_taken_o;
        wp_n        = wp_a + PTRW'(push);
        if (push && !full_a) cnt_n = cnt_a + CNT_ONE;
        else                 cnt_n = cnt_a;
        wr_en_o  = push;
        wr_idx_o = wp_a;
        rd_en_o  = pop_i;
        rd_idx_o = wp_q - PTRW'(1);
    end

    // occupancy state transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) state_n = ST_PARTIAL;            // first push
                else      state_n = ST_EMPTY;              // underflow pop / idle
            end
            ST_PARTIAL: begin
                if (pop_ok && !push && cnt_q == CNT_ONE)
                    state_n = ST_EMPTY;                    // last pop
                else if (push && !pop_ok && cnt_q == CNT_MAX - CNT_ONE)
                    state_n = ST_FULL;                     // filling push
                else
                    state_n = ST_PARTIAL;
            end
            ST_FULL: begin
                if (pop_ok && !push) state_n = ST_PARTIAL; // releasing pop
                else                 state_n = ST_FULL;    // overflow call / idle
            end
            default: state_n = ST_EMPTY;
        endcase
        full_nx_o = (state_n == ST_FULL);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
            wp_q    <= '0;
            undf_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            wp_q    <= wp_n;
            undf_q  <= pop_i && (cnt_q == '0);
        end
    end

    // outputs
    always_comb begin
        full_o      = (state_q == ST_FULL);
        empty_o     = (state_q == ST_EMPTY);
        underflow_o = undf_q;
    end

    a_r7_overflow_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && call_i && !pop_i) |=> full_o);
    a_r8_empty_pop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i) |=> underflow_o);
    a_r8_empty_pop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !call_i && !irq_push_i) |=> (empty_o && $stable(wp_q)));
    a_r3_push_leaves_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !pop_i) |=> !empty_o);
    a_r6_irq_ignored_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && irq_push_i && !call_i && !pop_i) |=> ($stable(wp_q) && full_o));
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));
endmodule

// File: rtl/retstk_store.sv
module retstk_store #(
    parameter int DEPTH = 8,
    parameter int PCW   = 13,
    localparam int PTRW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [PTRW-1:0] wr_idx_i,
    input  logic [PCW-1:0]  wr_data_i,
    input  logic            rd_en_i,
    input  logic [PTRW-1:0] rd_idx_i,
    output logic [PCW-1:0]  rd_data_o
);
    logic [PCW-1:0] slot_q [DEPTH];
    logic [PCW-1:0] ret_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en_i && wr_idx_i == PTRW'(g))
                slot_q[g] <= wr_data_i;
        end
    end

    // read sees the slot value from before this edge's write
    always_ff @(posedge clk) begin
        if (!rst_n)       ret_q <= '0;
        else if (rd_en_i) ret_q <= slot_q[rd_idx_i];
    end

    assign rd_data_o = ret_q;

    a_r1_ret_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(ret_q));
endmodule

// File: rtl/retstk_irq_gate.sv
module retstk_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req_i,
    input  logic irq_en_i,
    input  logic irq_taken_i,
    input  logic full_nx_i,
    output logic ack_ok_o
);
    logic pend_q, pend_n, ack_q;

    always_comb pend_n = (pend_q && !irq_taken_i) || irq_req_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            pend_q <= pend_n;
            ack_q  <= pend_n && irq_en_i && !full_nx_i;
        end
    end

    assign ack_ok_o = ack_q;

    a_r5_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !irq_taken_i) |=> pend_q);
    a_r10_taken_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken_i && !irq_req_i) |=> !pend_q);
    a_r4_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_i |=> pend_q);
endmodule

// File: rtl/retaddr_stack.sv
module retaddr_stack #(
    parameter int DEPTH = 8,
    parameter int PCW   = 13,
    localparam int PTRW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_call,
    input  logic           push_irq,
    input  logic           pop_req,
    input  logic [PCW-1:0] pc_in,
    input  logic           irq_req,
    input  logic           irq_en,
    output logic [PCW-1:0] ret_addr,
    output logic           full,
    output logic           empty,
    output logic           underflow,
    output logic           ack_ok
);
    logic            wr_en, rd_en, irq_taken, full_nx;
    logic [PTRW-1:0] wr_idx, rd_idx;

    retstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_i      (push_call),
        .irq_push_i  (push_irq),
        .pop_i       (pop_req),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .rd_en_o     (rd_en),
        .rd_idx_o    (rd_idx),
        .irq_taken_o (irq_taken),
        .full_nx_o   (full_nx),
        .full_o      (full),
        .empty_o     (empty),
        .underflow_o (underflow)
    );

    retstk_store #(.DEPTH(DEPTH), .PCW(PCW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (pc_in),
        .rd_en_i   (rd_en),
        .rd_idx_i  (rd_idx),
        .rd_data_o (ret_addr)
    );

    retstk_irq_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (irq_req),
        .irq_en_i    (irq_en),
        .irq_taken_i (irq_taken),
        .full_nx_i   (full_nx),
        .ack_ok_o    (ack_ok)
    );

    a_r5_no_ack_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !ack_ok);
endmodule

// File: tb/sim_retaddr_stack.sv
module sim_retaddr_stack;
    localparam int DEPTH = 8;
    localparam int PCW   = 13;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           push_call, push_irq, pop_req, irq_req, irq_en;
    logic [PCW-1:0] pc_in;
    logic [PCW-1:0] ret_addr;
    logic           full, empty, underflow, ack_ok;

    always #5 clk = ~clk;

    retaddr_stack #(.DEPTH(DEPTH), .PCW(PCW)) u0 (
        .clk(clk), .rst_n(rst_n), .push_call(push_call), .push_irq(push_irq),
        .pop_req(pop_req), .pc_in(pc_in), .irq_req(irq_req), .irq_en(irq_en),
        .ret_addr(ret_addr), .full(full), .empty(empty), .underflow(underflow),
        .ack_ok(ack_ok)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [PCW-1:0] m_mem [DEPTH];
    int             m_wp, m_cnt;
    logic [PCW-1:0] m_ret;
    logic           m_und, m_pend, m_ack;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
        m_wp = 0; m_cnt = 0; m_ret = '0; m_und = 0; m_pend = 0; m_ack = 0;
    endfunction

    function automatic void model_step(input logic c, input logic i, input logic p,
                                       input logic q, input logic e, input logic [PCW-1:0] pc);
        bit pop_ok, taken, push;
        int cnta, wpa;
        pop_ok = p && (m_cnt != 0);
        if (p) m_ret = m_mem[(m_wp + DEPTH - 1) % DEPTH];
        m_und = p && (m_cnt == 0);
        cnta  = m_cnt - int'(pop_ok);
        wpa   = (m_wp + DEPTH - int'(pop_ok)) % DEPTH;
        taken = i && (cnta != DEPTH);
        push  = c || taken;
        if (push) begin
            m_mem[wpa] = pc;
            m_wp  = (wpa + 1) % DEPTH;
            m_cnt = (cnta == DEPTH) ? DEPTH : cnta + 1;
        end else begin
            m_wp  = wpa;
            m_cnt = cnta;
        end
        m_pend = (m_pend && !taken) || q;
        m_ack  = m_pend && e && (m_cnt != DEPTH);
    endfunction

    task automatic compare_all();
        chk("R1 ret_addr", 32'(ret_addr), 32'(m_ret));
        chk("R3 full", 32'(full), 32'(m_cnt == DEPTH));
        chk("R3 empty", 32'(empty), 32'(m_cnt == 0));
        chk("R8 underflow", 32'(underflow), 32'(m_und));
        chk("R4 ack_ok", 32'(ack_ok), 32'(m_ack));
    endtask

    task automatic step(input logic c, input logic i, input logic p,
                        input logic q, input logic e, input logic [PCW-1:0] pc);
        @(negedge clk);
        push_call = c; push_irq = i; pop_req = p; irq_req = q; irq_en = e; pc_in = pc;
        @(posedge clk);
        model_step(c, i, p, q, e, pc);
        #1;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        push_call = 0; push_irq = 0; pop_req = 0; irq_req = 0; irq_en = 0; pc_in = '0;
        @(posedge clk); @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        do_reset();
        // R2: reset state
        chk("R2 empty", 32'(empty), 32'd1);
        chk("R2 full", 32'(full), 32'd0);
        chk("R2 ack_ok", 32'(ack_ok), 32'd0);
        chk("R2 underflow", 32'(underflow), 32'd0);
        chk("R2 ret_addr", 32'(ret_addr), 32'd0);

        // fill eight levels: R3
        for (int k = 0; k < DEPTH; k++) step(1, 0, 0, 0, 1, PCW'(100 + k));
        chk("R3 full after 8", 32'(full), 32'd1);
        // R5: request while full is held off
        step(0, 0, 0, 1, 1, '0);
        chk("R5 ack held", 32'(ack_ok), 32'd0);
        // R6: interrupt push on full stack ignored
        step(0, 1, 0, 0, 1, PCW'(777));
        step(0, 0, 1, 0, 1, '0);
        chk("R6 top unchanged", 32'(ret_addr), 32'd107);
        chk("R5 ack after pop", 32'(ack_ok), 32'd1);
        // R10: accepted interrupt push clears pending
        step(0, 1, 0, 0, 1, PCW'(200));
        chk("R10 pending cleared", 32'(ack_ok), 32'd0);
        chk("R3 full again", 32'(full), 32'd1);
        step(0, 0, 1, 0, 1, '0);
        chk("R1 lifo irq entry", 32'(ret_addr), 32'd200);

        // R7: overflow on calls
        do_reset();
        for (int k = 0; k < 10; k++) step(1, 0, 0, 0, 0, PCW'(300 + k));
        chk("R7 still full", 32'(full), 32'd1);
        for (int k = 0; k < DEPTH; k++) begin
            step(0, 0, 1, 0, 0, '0);
            chk("R7 newest first", 32'(ret_addr), 32'(309 - k));
        end
        chk("R3 empty after drain", 32'(empty), 32'd1);
        // R8: pop on empty
        step(0, 0, 1, 0, 0, '0);
        chk("R8 underflow pulse", 32'(underflow), 32'd1);
        chk("R8 value below pointer", 32'(ret_addr), 32'd309);
        step(0, 0, 0, 0, 0, '0);
        chk("R8 pulse ends", 32'(underflow), 32'd0);
        chk("R8 still empty", 32'(empty), 32'd1);

        // R9: simultaneous pop and push
        step(1, 0, 0, 0, 0, PCW'(400));
        step(1, 0, 1, 0, 0, PCW'(401));
        chk("R9 old top returned", 32'(ret_addr), 32'd400);
        chk("R9 occupancy kept", 32'(empty), 32'd0);
        step(0, 0, 1, 0, 0, '0);
        chk("R9 new entry in slot", 32'(ret_addr), 32'd401);
        chk("R9 empty after", 32'(empty), 32'd1);
        step(1, 0, 1, 0, 0, PCW'(500));
        chk("R9 underflow on empty", 32'(underflow), 32'd1);
        chk("R9 one entry", 32'(empty), 32'd0);
        step(0, 0, 1, 0, 0, '0);
        chk("R9 pushed value", 32'(ret_addr), 32'd500);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic c, i, p, q, e;
            c = ($urandom % 100) < 30;
            i = ($urandom % 100) < 15;
            p = ($urandom % 100) < 30;
            q = ($urandom % 100) < 10;
            e = ($urandom % 100) < 75;
            step(c, i, p, q, e, PCW'($urandom));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule